// File: doc/BRIEF.md
# Software Trap Vectoring Unit

This block carries out a software interrupt for a small processor core. A trap request carries a 6-bit vector number and a flag that asks for interrupts to be disabled. On acceptance, the unit saves the core's present context on an internal return stack. That context is the program counter, the global interrupt enable, the ALU flags and the register-bank select. Two cycles after acceptance it hands back a new context. The new program counter is formed by placing the vector-base register in the high byte and the vector number, shifted left by two, in the low byte. The hardware interrupt sources use the same table of 64 entries, so software can imitate any of them by issuing a trap with the matching vector (for example 4, 8, 12, 16, 20 or 28).

A return request pops the newest saved context and presents it as the update one cycle after acceptance. Requests use a valid/ready handshake. `req_ready` drops for the second cycle of a trap, and the core must hold `req_valid` and the request fields until it sees ready. The update port has no back-pressure. `upd_valid` is a single-cycle pulse, and the core must load the update in that cycle. The stack wraps when full and keeps sticky error flags.

Top module: `trap_vector_unit`

## Requirements
- R1: An accepted trap produces an update whose `upd_pc` equals `{base_q, req_vec, 2'b00}`, using the base value held at acceptance. This holds for every vector from 0 to 63.
- R2: With `req_g`=1 the trap update has `upd_gie`=0. With `req_g`=0 it carries `cur_gie` unchanged.
- R3: A trap update passes `cur_flags` and `cur_bank` from acceptance through unchanged.
- R4: A trap takes two cycles. `req_ready` is low in the cycle after acceptance, and `upd_valid` pulses for one cycle after the second clock edge.
- R5: A return (`req_op`=1; a trap is `req_op`=0) on a non-empty stack pulses `upd_valid` in the cycle after acceptance. It restores pc, gie, flags and bank exactly as the newest unpopped trap saved them, in last-in first-out order.
- R6: `stk_depth` counts the saved entries and never exceeds the stack depth of 12.
- R7: A trap on a full stack overwrites the oldest entry, sets `stk_ovf`, and leaves the depth at 12. `stk_ovf` stays set until reset.
- R8: A return on an empty stack gives no update pulse and leaves the depth at 0. It sets `stk_unf`, which stays set until reset.
- R9: After reset, `req_ready`=1, `upd_valid`=0, `stk_depth`=0, `stk_ovf`=0, `stk_unf`=0 and `base_q`=0.
- R10: `base_wr`=1 loads `base_wdata` into the base register at the clock edge, and `base_q` shows it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 1 | 0 = trap, 1 = return |
| req_vec | input | 6 | Trap vector number |
| req_g | input | 1 | Disable interrupts on trap |
| cur_pc | input | 16 | Core program counter to save |
| cur_gie | input | 1 | Core interrupt enable to save |
| cur_flags | input | 4 | Core ALU flags to save |
| cur_bank | input | 2 | Core bank select to save |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 8 | Base register write value |
| base_q | output | 8 | Base register contents |
| upd_valid | output | 1 | Context update pulse |
| upd_pc | output | 16 | New program counter |
| upd_gie | output | 1 | New interrupt enable |
| upd_flags | output | 4 | New ALU flags |
| upd_bank | output | 2 | New bank select |
| stk_depth | output | 4 | Saved entries |
| stk_ovf | output | 1 | Sticky overflow |
| stk_unf | output | 1 | Sticky underflow |

## Verification
The hardest state to reach is the wrapped stack. It appears only after thirteen back-to-back traps with no return, and the overwritten oldest entry shows up only as a context that never comes back. The stimulus nests thirteen traps with distinct contexts. It then unwinds with thirteen returns, so the scoreboard sees the twelve survivors in reverse order and nothing for the last return. Separately, each of the 64 vectors is driven as a trap and return pair with `g` alternating.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int BASE_W = 8;
  localparam int VEC_W  = 6;
  localparam int FLAG_W = 4;
  localparam int BANK_W = 2;
  localparam int PAD_W  = 2;
  localparam int PC_W   = BASE_W + VEC_W + PAD_W;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic              gie;
    logic [FLAG_W-1:0] flags;
    logic [BANK_W-1:0] bank;
  } ctx_t;

  typedef enum logic {
    OP_TRAP = 1'b0,
    OP_RET  = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } seq_state_e;
endpackage

// File: rtl/trap_vector_base.sv
module trap_vector_base
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wr_data,
  input  logic [VEC_W-1:0]  vec,
  output logic [BASE_W-1:0] base_q,
  output logic [PC_W-1:0]   target
);
  logic [BASE_W-1:0] base_r;

  always_ff @(posedge clk) begin
    if (!rst_n) base_r <= '0;
    else if (wr_en) base_r <= wr_data;
  end

  assign base_q = base_r;
  assign target = {base_r, vec, {PAD_W{1'b0}}};

  assert_base_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q == $past(wr_data)));
endmodule

// File: rtl/trap_ctx_stack.sv
module trap_ctx_stack
  import trap_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  ctx_t                       push_data,
  output ctx_t                       top_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full,
  output logic                       ovf,
  output logic                       unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  ctx_t            mem [DEPTH];
  logic [PW-1:0]   wr_ptr;
  logic [PW-1:0]   rd_idx;
  logic [CW-1:0]   cnt;

  assign rd_idx   = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign top_data = mem[rd_idx];
  assign count    = cnt;
  assign empty    = (cnt == '0);
  assign full     = (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (push) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end else if (pop) begin
      if (empty) unf <= 1'b1;
      else begin
        wr_ptr <= rd_idx;
        cnt    <= cnt - 1'b1;
      end
    end
  end

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  assert_no_dual_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (full && ovf));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (empty && unf));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_op,
  input  logic            req_g,
  input  ctx_t            cur_ctx,
  input  logic [PC_W-1:0] target,
  input  ctx_t            top_data,
  input  logic            stk_empty,
  output logic            req_ready,
  output logic            push,
  output ctx_t            push_data,
  output logic            pop,
  output logic            upd_valid,
  output ctx_t            upd_ctx
);
  seq_state_e state;
  ctx_t       pend;
  logic       accept;
  logic       is_trap;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_trap   = (req_op == OP_TRAP);
  assign push      = accept && is_trap;
  assign pop       = accept && !is_trap;
  assign push_data = cur_ctx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend      <= '0;
      upd_valid <= 1'b0;
      upd_ctx   <= '0;
    end else begin
      upd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && is_trap) begin
            state      <= ST_EXEC;
            pend.pc    <= target;
            pend.gie   <= req_g ? 1'b0 : cur_ctx.gie;
            pend.flags <= cur_ctx.flags;
            pend.bank  <= cur_ctx.bank;
          end else if (accept && !stk_empty) begin
            upd_valid <= 1'b1;
            upd_ctx   <= top_data;
          end
        end
        ST_EXEC: begin
          state     <= ST_IDLE;
          upd_valid <= 1'b1;
          upd_ctx   <= pend;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_trap_two_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_trap) |=> (!req_ready && !upd_valid) ##1 upd_valid);
  assert_gie_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_trap && req_g) |=> ##1 !upd_ctx.gie);
  assert_flags_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_trap) |=> ##1 (upd_ctx.flags == $past(cur_ctx.flags, 2)));
  assert_ret_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_trap && !stk_empty) |=> upd_valid);
  assert_ret_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_trap && stk_empty) |=> !upd_valid);
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_pkg::*;
#(
  parameter int STACK_DEPTH = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_op,
  input  logic [5:0]                       req_vec,
  input  logic                             req_g,
  input  logic [15:0]                      cur_pc,
  input  logic                             cur_gie,
  input  logic [3:0]                       cur_flags,
  input  logic [1:0]                       cur_bank,
  input  logic                             base_wr,
  input  logic [7:0]                       base_wdata,
  output logic [7:0]                       base_q,
  output logic                             upd_valid,
  output logic [15:0]                      upd_pc,
  output logic                             upd_gie,
  output logic [3:0]                       upd_flags,
  output logic [1:0]                       upd_bank,
  output logic [$clog2(STACK_DEPTH+1)-1:0] stk_depth,
  output logic                             stk_ovf,
  output logic                             stk_unf
);
  ctx_t            cur_ctx, push_data, top_data, upd_ctx;
  logic [PC_W-1:0] target;
  logic            push, pop, stk_empty, stk_full;

  assign cur_ctx.pc    = cur_pc;
  assign cur_ctx.gie   = cur_gie;
  assign cur_ctx.flags = cur_flags;
  assign cur_ctx.bank  = cur_bank;

  trap_vector_base u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr),
    .wr_data (base_wdata),
    .vec     (req_vec),
    .base_q  (base_q),
    .target  (target)
  );

  trap_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_g     (req_g),
    .cur_ctx   (cur_ctx),
    .target    (target),
    .top_data  (top_data),
    .stk_empty (stk_empty),
    .req_ready (req_ready),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .upd_valid (upd_valid),
    .upd_ctx   (upd_ctx)
  );

  trap_ctx_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .top_data  (top_data),
    .count     (stk_depth),
    .empty     (stk_empty),
    .full      (stk_full),
    .ovf       (stk_ovf),
    .unf       (stk_unf)
  );

  assign upd_pc    = upd_ctx.pc;
  assign upd_gie   = upd_ctx.gie;
  assign upd_flags = upd_ctx.flags;
  assign upd_bank  = upd_ctx.bank;

  assert_full_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> (stk_depth == STACK_DEPTH));
endmodule

// File: tb/sim_trap_vector_unit.sv
module sim_trap_vector_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_op = 1'b0, req_g = 1'b0;
  logic [5:0]  req_vec = '0;
  logic [15:0] cur_pc = '0;
  logic        cur_gie = 1'b0;
  logic [3:0]  cur_flags = '0;
  logic [1:0]  cur_bank = '0;
  logic        base_wr = 1'b0;
  logic [7:0]  base_wdata = '0;
  logic        req_ready, upd_valid, upd_gie, stk_ovf, stk_unf;
  logic [7:0]  base_q;
  logic [15:0] upd_pc;
  logic [3:0]  upd_flags;
  logic [1:0]  upd_bank;
  logic [3:0]  stk_depth;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [22:0] exp_q[$];
  logic [22:0] model[$];
  logic [7:0]  base_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_vector_unit #(.STACK_DEPTH(DEPTH)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every update pulse
  always @(negedge clk) begin
    if (rst_n && upd_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected update", 1, 0);
      else check("R1 R2 R3 R5 update", {upd_pc, upd_gie, upd_flags, upd_bank}, exp_q.pop_front());
    end
  end

  task automatic do_trap(input logic [5:0] v, input logic g, input logic [15:0] pc,
                         input logic gie, input logic [3:0] fl, input logic [1:0] bk);
    @(negedge clk);
    req_valid = 1; req_op = 0; req_vec = v; req_g = g;
    cur_pc = pc; cur_gie = gie; cur_flags = fl; cur_bank = bk;
    exp_q.push_back({base_model, v, 2'b00, g ? 1'b0 : gie, fl, bk});
    model.push_back({pc, gie, fl, bk});
    if (model.size() > DEPTH) void'(model.pop_front());
    @(negedge clk);
    check("R4 ready low in second cycle", req_ready, 0);
    req_valid = 0;
    @(negedge clk);
    check("R4 ready back", req_ready, 1);
  endtask

  task automatic do_return();
    @(negedge clk);
    req_valid = 1; req_op = 1;
    if (model.size() > 0) exp_q.push_back(model.pop_back());
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 ready", req_ready, 1);
    check("R9 upd_valid", upd_valid, 0);
    check("R9 depth", stk_depth, 0);
    check("R9 ovf", stk_ovf, 0);
    check("R9 unf", stk_unf, 0);
    check("R9 base", base_q, 0);

    // R10: base register load
    base_wr = 1; base_wdata = 8'hA5;
    @(negedge clk);
    base_wr = 0; base_model = 8'hA5;
    check("R10 base load", base_q, 8'hA5);

    // R1 R2: every vector, g alternating, each followed by a return (R5)
    for (int v = 0; v < 64; v++) begin
      do_trap(6'(v), v[0], 16'(v * 16'h0301 + 7), ~v[1], 4'(v), 2'(v >> 2));
      check("R6 depth after trap", stk_depth, 1);
      do_return();
      check("R6 depth after return", stk_depth, 0);
    end

    base_wr = 1; base_wdata = 8'h3C;
    @(negedge clk);
    base_wr = 0; base_model = 8'h3C;

    // R7: nest thirteen traps, the first is lost
    for (int i = 0; i < DEPTH + 1; i++) begin
      do_trap(6'(i * 4), 1'b0, 16'h1000 + 16'(i), i[0], 4'(15 - i), 2'(i));
      if (i == DEPTH - 1) begin
        check("R6 depth full", stk_depth, DEPTH);
        check("R7 ovf clear at full", stk_ovf, 0);
      end
    end
    check("R7 depth holds", stk_depth, DEPTH);
    check("R7 ovf set", stk_ovf, 1);

    // R5: unwind LIFO; R8: last return on empty
    for (int i = 0; i < DEPTH; i++) do_return();
    check("R6 depth drained", stk_depth, 0);
    check("R8 unf clear before", stk_unf, 0);
    do_return();
    @(negedge clk);
    check("R8 unf set", stk_unf, 1);
    check("R8 depth zero", stk_depth, 0);
    check("R7 ovf sticky", stk_ovf, 1);
    repeat (2) @(negedge clk);
    check("R8 unf sticky", stk_unf, 1);
    check("R5 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule